// File: doc/BRIEF.md
# Bus transceiver mode controller

This block holds the digital mode and supply control of a single-wire vehicle bus transceiver. It decides from the host's control pins whether the line driver may switch the bus. When it may, it chooses between shaped edges and fast edges. It also decides what the receive pin reports. The analog parts are replaced by plain bits: the bus comparator result arrives as a sampled bus-active bit, and the driver and slew shaping are controlled through an enable and a fast-edge select.

The block also owns the enable of the external voltage regulator. A falling standby line is taken as a request to power down. The regulator enable then stays on for a programmable count of clock cycles and drops only if nothing wakes the node during that window. Three things bring it back from sleep: bus activity, any edge on the local wake-up pin, or the standby line going high again. A thermal latch holds the driver off after an over-temperature event. The latch re-arms only on a fresh rising transmit bit that arrives once the temperature flag is clear.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After reset, and in the cycle after any clock edge that samples the power-on pulse high, the mode code is 0 (standby), the regulator enable is high, and the driver enable and fast-edge select are low.
- R2: With standby high, the mode-select code picks the mode one clock edge after the standby level has passed its synchroniser. Code 2'b00 gives normal (mode code 1). Code 2'b01 gives fast (code 2). Code 2'b10 (floating) and the unused code 2'b11 give loopback (code 3).
- R3: While the standby line stays low and no sleep request has been made, the block remains in standby (code 0) with the regulator enable high and the driver enable low.
- R4: In normal and fast modes the driver enable follows the transmit bit. The fast-edge select is high in fast mode and low in every other mode.
- R5: In loopback the driver enable is low whatever the transmit bit is. The receive output is the inverse of the transmit bit, and the bus-active bit has no effect on it.
- R6: In every mode other than loopback, the receive output is low while the bus-active bit is high and high while it is low.
- R7: Standby falling while in normal, fast or loopback enters sleep-pending (code 4) with the regulator enable still high. Exactly SLEEP_CYCLES clock cycles later the block enters sleep (code 5) and the regulator enable drops.
- R8: A wake condition during sleep-pending cancels the time-out, and the regulator enable never drops. The wake conditions are bus activity, a local wake-up edge, or standby high. The block goes back to standby, or to the selected active mode if standby is high.
- R9: In sleep, bus activity, a rising or a falling local wake-up edge, or a high standby level raises the regulator enable again. The block leaves sleep for standby, or for the selected active mode when standby is high.
- R10: A high over-temperature bit latches the driver off. The latch survives the flag clearing and a transmit rising edge seen while the flag is still high. It clears on the first transmit rising edge that occurs while the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| por_i | input | 1 | Power-on reset pulse, active high, forces standby |
| stby_i | input | 1 | Standby control pin (low or floating means standby) |
| msel_i | input | 2 | Mode select: 00 low, 01 high, 10 floating |
| txd_i | input | 1 | Transmit data bit, high means drive the bus active |
| bus_act_i | input | 1 | Sampled bus comparator, high when the bus is active |
| lwake_i | input | 1 | Local wake-up pin, both edges count |
| otemp_i | input | 1 | Over-temperature flag |
| drv_en_o | output | 1 | Bus driver enable |
| fast_edge_o | output | 1 | Waveshape bypass select |
| rxd_o | output | 1 | Receive data, low when the bus (or looped transmit) is active |
| reg_en_o | output | 1 | Regulator enable (inhibit) output |
| mode_o | output | 3 | Mode code: 0 standby, 1 normal, 2 fast, 3 loopback, 4 sleep-pending, 5 sleep |

## Verification
The bench builds the block with SLEEP_CYCLES set to 16 instead of the long default. The whole power-down window can then be counted cycle by cycle, and the block can be put to sleep and woken several times in one short run, once through each wake source. The short window also leaves room to inject a wake halfway through sleep-pending and to watch the regulator enable hold.

// File: rtl/xcvr_ctl_pkg.sv
package xcvr_ctl_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_NORMAL  = 3'd1,
    MD_FAST    = 3'd2,
    MD_LOOP    = 3'd3,
    MD_PEND    = 3'd4,
    MD_SLEEP   = 3'd5
  } mode_e;

  localparam logic [1:0] SEL_LOW   = 2'b00;
  localparam logic [1:0] SEL_HIGH  = 2'b01;
  localparam logic [1:0] SEL_FLOAT = 2'b10;

  // Active mode picked by the select code; the unused code is treated as
  // floating so that it keeps the node off the bus.
  function automatic mode_e sel_to_mode(input logic [1:0] sel);
    mode_e m;
    case (sel)
      SEL_LOW:   m = MD_NORMAL;
      SEL_HIGH:  m = MD_FAST;
      SEL_FLOAT: m = MD_LOOP;
      default:   m = MD_LOOP;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/xcvr_therm_latch.sv
module xcvr_therm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic otemp,
  input  logic txd,
  output logic latched
);

  logic tx_q;
  logic lat_q, lat_d;
  logic tx_rise;

  assign tx_rise = txd & ~tx_q;

  always_comb begin
    lat_d = lat_q;
    if (otemp)                lat_d = 1'b1;
    else if (lat_q && tx_rise) lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      tx_q  <= txd;
      lat_q <= lat_d;
    end
  end

  assign latched = lat_q;

  assert_ot_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    otemp |=> latched);

  assert_clear_when_cool_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched) |-> $past(!otemp && txd));

endmodule

// File: rtl/xcvr_power_fsm.sv
module xcvr_power_fsm
  import xcvr_ctl_pkg::*;
#(
  parameter int SLEEP_CYCLES = 65536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por,
  input  logic       stby_s,
  input  logic [1:0] msel,
  input  logic       bus_act,
  input  logic       lwake_edge,
  output mode_e      mode
);

  localparam int CNT_W = (SLEEP_CYCLES > 2) ? $clog2(SLEEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SLEEP_CYCLES - 1);

  mode_e            st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_ld, cnt_dec;
  logic             wake;
  mode_e            act_mode;

  assign wake     = bus_act | lwake_edge | stby_s;
  assign act_mode = sel_to_mode(msel);

  always_comb begin
    st_d    = st_q;
    cnt_ld  = 1'b0;
    cnt_dec = 1'b0;
    case (st_q)
      MD_STANDBY: begin
        if (stby_s) st_d = act_mode;
      end
      MD_NORMAL, MD_FAST, MD_LOOP: begin
        if (!stby_s) begin
          st_d   = MD_PEND;
          cnt_ld = 1'b1;
        end else begin
          st_d = act_mode;
        end
      end
      MD_PEND: begin
        if (wake)              st_d = stby_s ? act_mode : MD_STANDBY;
        else if (cnt_q == '0)  st_d = MD_SLEEP;
        else                   cnt_dec = 1'b1;
      end
      MD_SLEEP: begin
        if (wake) st_d = stby_s ? act_mode : MD_STANDBY;
      end
      default: st_d = MD_STANDBY;
    endcase
    if (por) begin
      st_d    = MD_STANDBY;
      cnt_ld  = 1'b0;
      cnt_dec = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= MD_STANDBY;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_ld)  cnt_q <= CNT_LOAD;
    else if (cnt_dec) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign mode = st_q;

  assert_por_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> (st_q == MD_STANDBY));

  assert_sleep_via_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MD_SLEEP) && ($past(st_q) != MD_SLEEP)) |-> ($past(st_q) == MD_PEND));

  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MD_PEND) && ($past(st_q) == MD_PEND)) |-> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_sleep_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MD_SLEEP) && wake) |=> (st_q != MD_SLEEP));

endmodule

// File: rtl/xcvr_line_path.sv
module xcvr_line_path
  import xcvr_ctl_pkg::*;
(
  input  mode_e mode,
  input  logic  txd,
  input  logic  bus_act,
  input  logic  latched,
  output logic  drv_en,
  output logic  fast_edge,
  output logic  rxd,
  output logic  reg_en
);

  logic tx_mode;

  always_comb begin
    tx_mode   = (mode == MD_NORMAL) || (mode == MD_FAST);
    drv_en    = tx_mode & txd & ~latched;
    fast_edge = (mode == MD_FAST);
    rxd       = (mode == MD_LOOP) ? ~txd : ~bus_act;
    reg_en    = (mode != MD_SLEEP);
  end

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_ctl_pkg::*;
#(
  parameter int SLEEP_CYCLES = 65536,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       stby_i,
  input  logic [1:0] msel_i,
  input  logic       txd_i,
  input  logic       bus_act_i,
  input  logic       lwake_i,
  input  logic       otemp_i,
  output logic       drv_en_o,
  output logic       fast_edge_o,
  output logic       rxd_o,
  output logic       reg_en_o,
  output logic [2:0] mode_o
);

  logic [1:0] rst_q;
  logic       rst_int_n;
  logic [1:0] pins_s;
  logic       stby_s, lwake_s, lwake_q, lwake_edge;
  logic       latched;
  mode_e      mode;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  xcvr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({stby_i, lwake_i}),
    .q     (pins_s)
  );
  assign stby_s  = pins_s[1];
  assign lwake_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) lwake_q <= 1'b0;
    else            lwake_q <= lwake_s;
  end
  assign lwake_edge = lwake_s ^ lwake_q;

  xcvr_power_fsm #(.SLEEP_CYCLES(SLEEP_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .por        (por_i),
    .stby_s     (stby_s),
    .msel       (msel_i),
    .bus_act    (bus_act_i),
    .lwake_edge (lwake_edge),
    .mode       (mode)
  );

  xcvr_therm_latch u_therm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .otemp   (otemp_i),
    .txd     (txd_i),
    .latched (latched)
  );

  xcvr_line_path u_path (
    .mode      (mode),
    .txd       (txd_i),
    .bus_act   (bus_act_i),
    .latched   (latched),
    .drv_en    (drv_en_o),
    .fast_edge (fast_edge_o),
    .rxd       (rxd_o),
    .reg_en    (reg_en_o)
  );

  assign mode_o = mode;

  assert_loop_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MD_LOOP) |-> !drv_en_o);

  assert_latch_blocks_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    latched |-> !drv_en_o);

  assert_reg_drop_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(reg_en_o) |-> ($past(mode) == MD_PEND));

endmodule

// File: tb/xcvr_mode_ctrl_test.sv
`timescale 1ns/1ps
module xcvr_mode_ctrl_test;

  localparam int SLP = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       por_i, stby_i, txd_i, bus_act_i, lwake_i, otemp_i;
  logic [1:0] msel_i;
  logic       drv_en_o, fast_edge_o, rxd_o, reg_en_o;
  logic [2:0] mode_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xcvr_mode_ctrl #(.SLEEP_CYCLES(SLP)) uut (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .stby_i(stby_i), .msel_i(msel_i),
    .txd_i(txd_i), .bus_act_i(bus_act_i), .lwake_i(lwake_i), .otemp_i(otemp_i),
    .drv_en_o(drv_en_o), .fast_edge_o(fast_edge_o), .rxd_o(rxd_o),
    .reg_en_o(reg_en_o), .mode_o(mode_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic enter_sleep();
    stby_i = 1'b1; msel_i = 2'b00;
    step(4);
    stby_i = 1'b0;
    step(SLP + 10);
    chk("R7 sleep reached", mode_o, 5);
    chk("R7 regulator off in sleep", reg_en_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 mode after reset", mode_o, 0);
    chk("R1 regulator on after reset", reg_en_o, 1);
    chk("R1 driver off after reset", drv_en_o, 0);
    chk("R1 fast select off after reset", fast_edge_o, 0);
    txd_i = 1'b1; step(6);
    chk("R3 standby held with pin low", mode_o, 0);
    chk("R3 driver off in standby", drv_en_o, 0);
    chk("R3 regulator on in standby", reg_en_o, 1);
    txd_i = 1'b0;
    chk("R6 rx idle in standby", rxd_o, 1);
    bus_act_i = 1'b1; step(1);
    chk("R6 rx shows bus in standby", rxd_o, 0);
    bus_act_i = 1'b0; step(1);
  endtask

  task automatic t_modes();
    stby_i = 1'b1; msel_i = 2'b00; step(4);
    chk("R2 select 00 gives normal", mode_o, 1);
    txd_i = 1'b1; step(1);
    chk("R4 normal driver follows tx high", drv_en_o, 1);
    chk("R4 normal fast select low", fast_edge_o, 0);
    txd_i = 1'b0; step(1);
    chk("R4 normal driver follows tx low", drv_en_o, 0);
    bus_act_i = 1'b1; step(1);
    chk("R6 rx low on active bus in normal", rxd_o, 0);
    bus_act_i = 1'b0;
    msel_i = 2'b01; step(2);
    chk("R2 select 01 gives fast", mode_o, 2);
    chk("R4 fast select high", fast_edge_o, 1);
    txd_i = 1'b1; step(1);
    chk("R4 fast driver follows tx", drv_en_o, 1);
    msel_i = 2'b10; step(2);
    chk("R2 select 10 gives loopback", mode_o, 3);
    chk("R5 loopback driver off", drv_en_o, 0);
    chk("R5 loopback rx low on tx high", rxd_o, 0);
    chk("R4 loopback fast select low", fast_edge_o, 0);
    txd_i = 1'b0; bus_act_i = 1'b1; step(1);
    chk("R5 loopback ignores bus", rxd_o, 1);
    bus_act_i = 1'b0;
    msel_i = 2'b11; step(2);
    chk("R2 select 11 gives loopback", mode_o, 3);
    msel_i = 2'b00; step(2);
  endtask

  task automatic t_thermal();
    txd_i = 1'b1; otemp_i = 1'b1; step(2);
    chk("R10 driver off on over-temp", drv_en_o, 0);
    txd_i = 1'b0; step(1); txd_i = 1'b1; step(2);
    chk("R10 rise while hot keeps latch", drv_en_o, 0);
    otemp_i = 1'b0; step(3);
    chk("R10 latch survives cooling", drv_en_o, 0);
    txd_i = 1'b0; step(1); txd_i = 1'b1; step(1);
    chk("R10 rise when cool re-arms", drv_en_o, 1);
    txd_i = 1'b0; step(1);
  endtask

  task automatic t_sleep_timing();
    int n;
    stby_i = 1'b1; msel_i = 2'b00; step(4);
    stby_i = 1'b0;
    n = 0;
    while (mode_o != 3'd4 && n < 20) begin step(1); n++; end
    chk("R7 sleep-pending entered", mode_o, 4);
    chk("R7 regulator on while pending", reg_en_o, 1);
    n = 0;
    while (mode_o != 3'd5 && n < 100) begin step(1); n++; end
    chk("R7 pending length in cycles", n, SLP);
    chk("R7 regulator off after time-out", reg_en_o, 0);
  endtask

  task automatic t_wakes();
    bus_act_i = 1'b1; step(2);
    chk("R9 bus wake leaves sleep", mode_o, 0);
    chk("R9 bus wake regulator on", reg_en_o, 1);
    bus_act_i = 1'b0; step(1);
    enter_sleep();
    lwake_i = 1'b1; step(4);
    chk("R9 rising local wake", mode_o, 0);
    chk("R9 rising local wake regulator on", reg_en_o, 1);
    enter_sleep();
    lwake_i = 1'b0; step(4);
    chk("R9 falling local wake", mode_o, 0);
    enter_sleep();
    stby_i = 1'b1; msel_i = 2'b01; step(4);
    chk("R9 standby high wakes to fast", mode_o, 2);
    chk("R9 standby wake regulator on", reg_en_o, 1);
  endtask

  task automatic t_cancel();
    int n;
    bit dropped;
    stby_i = 1'b1; msel_i = 2'b00; step(4);
    stby_i = 1'b0;
    n = 0;
    while (mode_o != 3'd4 && n < 20) begin step(1); n++; end
    step(5);
    bus_act_i = 1'b1; step(1);
    chk("R8 bus wake cancels pending", mode_o, 0);
    bus_act_i = 1'b0;
    dropped = 1'b0;
    for (int i = 0; i < 2*SLP; i++) begin
      step(1);
      if (!reg_en_o) dropped = 1'b1;
    end
    chk("R8 regulator never dropped", dropped, 0);
    chk("R8 standby after cancel", mode_o, 0);
  endtask

  task automatic t_por();
    stby_i = 1'b1; msel_i = 2'b01; step(4);
    chk("R2 fast before power-on pulse", mode_o, 2);
    por_i = 1'b1; step(1);
    chk("R1 power-on pulse forces standby", mode_o, 0);
    chk("R1 power-on pulse regulator on", reg_en_o, 1);
    chk("R1 power-on pulse fast select off", fast_edge_o, 0);
    por_i = 1'b0; step(1);
  endtask

  initial begin
    rst_n = 1'b0; por_i = 1'b0; stby_i = 1'b0; msel_i = 2'b00; txd_i = 1'b0;
    bus_act_i = 1'b0; lwake_i = 1'b0; otemp_i = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_modes();
    t_thermal();
    t_sleep_timing();
    t_wakes();
    t_cancel();
    t_por();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule